// File: doc/BRIEF.md
# Dual-Clock FIFO With Ready Flags

This block is a first-in first-out buffer that sits between two unrelated clock domains. A producer writes 18-bit words on its own free-running clock and a consumer takes them out on another. Each side sees one ready flag in its own domain. The write side sees whether there is room for a word. The read side sees whether a word is waiting on the output register. The write side also carries a half-full indication.

The read port has a prefetch stage. The first word that enters an empty buffer moves onto the output register without any read request. It then waits there until the consumer takes it with output enable and both read enables. The output register counts as storage, so the buffer holds the 1024 memory words plus one word in the output stage. Binary pointers with one wrap bit are turned into Gray code and pass through two-flop synchronisers into the opposite domain. The reset input is active low and is sampled by a two-flop synchroniser on each clock. Because of this, every flag moves a fixed number of clock edges after a reset edge, a first write, a full condition or the last read.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored at a rising write-clock edge only when in_rdy and both write enables are high. A word offered while in_rdy is low is discarded and never appears at the output.
- R2: A word leaves the output register at a rising read-clock edge only when out_rdy, out_en and both read enables are high. Otherwise rd_data and out_rdy hold their values.
- R3: The first word written into an empty buffer appears on rd_data, with out_rdy high, after the third rising read-clock edge that follows its write. This happens whatever the read enables and out_en are doing, and the word is presented exactly once.
- R4: When the word being taken is the last one held, out_rdy goes low at that same read-clock edge.
- R5: Total capacity is 1025 words: 1024 in memory and 1 in the output register. Once the buffer holds 1025 words, in_rdy is low.
- R6: After a full buffer is relieved by a read, in_rdy rises after the second rising write-clock edge that follows that read edge.
- R7: When rst_n goes low, in_rdy falls after the second write-clock edge and out_rdy falls after the third read-clock edge. half_full is low during reset and the buffer is empty afterwards.
- R8: After rst_n is released, in_rdy rises after the second rising write-clock edge.
- R9: half_full is high when the write side sees 513 or more words in memory (words not yet moved to the output register) and low at 512 or fewer. The flag is registered on the write clock.
- R10: Words leave in the order they were accepted, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Free-running write clock |
| rd_clk | input | 1 | Free-running read clock |
| rst_n | input | 1 | Active-low reset, hold at least four cycles of each clock |
| wr_data | input | 18 | Word to store |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| in_rdy | output | 1 | Room available, write-clock domain |
| half_full | output | 1 | 513 or more words in memory, write-clock domain |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable, also required for a read |
| rd_data | output | 18 | Output register |
| out_rdy | output | 1 | Output register holds a word, read-clock domain |

## Verification
The hardest state to reach is the full boundary. in_rdy drops only after 1025 accepted words, and it must rise again exactly two write edges after one read. The stimulus holds out_en low, streams writes with consecutive data values and counts acceptances until in_rdy falls. It then pulses a single read and counts write-clock edges. Between these steps it checks half_full on both sides of 512 memory words. It also offers extra writes while full, and the later drain shows that those words were discarded. The first-word latency is checked twice, once with the read enables low and once with them high. The reset edge counts are checked from a buffer that still holds data.

// File: rtl/cdc_sync.sv
// Multi-stage synchroniser: a plain shift of N flops, no reset.
module cdc_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [N-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    stg <= {stg[N-2:0], d};
  end

  assign q = stg[N-1];
endmodule

// File: rtl/xfifo_ram.sv
// Storage array: one write port on the write clock, an asynchronous read port.
module xfifo_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/xfifo_wr.sv
// Write side: pointer, fill level seen from the write domain, ready and half-full flags.
module xfifo_wr #(
  parameter int ADDR_W = 10
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wrst_n,
  input  logic              we_a,
  input  logic              we_b,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              push,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              ir,
  output logic              hf
);
  localparam int PW     = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HF_LVL = DEPTH / 2 + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HF_CNT   = PW'(HF_LVL);

  logic [PW-1:0] wptr, wptr_n, wgray_n, rbin, fill;
  logic          full, hf_n;

  // next state
  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
    fill    = wptr - rbin;
    full    = (fill == FULL_CNT);
    ir      = wrst_n & ~full;
    push    = ir & we_a & we_b;
    wptr_n  = wrst_n ? (wptr + PW'(push)) : '0;
    wgray_n = wptr_n ^ (wptr_n >> 1);
    hf_n    = wrst_n & (fill >= HF_CNT);
  end

  // registers
  always_ff @(posedge wclk) begin
    wptr  <= wptr_n;
    wgray <= wgray_n;
    hf    <= hf_n;
  end

  assign waddr = wptr[ADDR_W-1:0];

  assert_drop_when_full_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    (wrst_n && !ir && we_a && we_b) |=> $stable(wptr));
  assert_fill_bound_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    wrst_n |-> (fill <= FULL_CNT));
  assert_hf_reset_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    !wrst_n |=> !hf);
endmodule

// File: rtl/xfifo_rd.sv
// Read side: pointer, prefetching output register and output-ready flag.
module xfifo_rd #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              rrst_n,
  input  logic              oe,
  input  logic              re_a,
  input  logic              re_b,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] q,
  output logic              valid
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rptr, rptr_n, rgray_n, wbin;
  logic          mem_has, unload, load, valid_n;

  // next state
  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
    mem_has = (rptr != wbin);
    unload  = valid & oe & re_a & re_b;
    load    = rrst_n & mem_has & (~valid | unload);
    if (!rrst_n)     valid_n = 1'b0;
    else if (load)   valid_n = 1'b1;
    else if (unload) valid_n = 1'b0;
    else             valid_n = valid;
    rptr_n  = rrst_n ? (rptr + PW'(load)) : '0;
    rgray_n = rptr_n ^ (rptr_n >> 1);
  end

  // registers
  always_ff @(posedge rclk) begin
    valid <= valid_n;
    rptr  <= rptr_n;
    rgray <= rgray_n;
    if (load) q <= rdata;
  end

  assign raddr = rptr[ADDR_W-1:0];

  assert_hold_without_read_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    (rrst_n && valid && !(oe && re_a && re_b)) |=> (valid && $stable(q)));
  assert_no_load_from_empty_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (rrst_n && !valid && !mem_has) |=> !valid);
  assert_last_read_drops_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (rrst_n && unload && !mem_has) |=> !valid);
  assert_reset_clears_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    !rrst_n |=> !valid);
endmodule

// File: rtl/xclk_fifo.sv
// Top: reset synchronisers, pointer crossings, write side, read side and storage.
module xclk_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  parameter int SYNC_N = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  output logic              in_rdy,
  output logic              half_full,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_rdy
);
  localparam int PW = ADDR_W + 1;

  logic              wrst_n, rrst_n, push;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] mem_q;

  cdc_sync #(.W(1), .N(SYNC_N)) u_wrst (.clk(wr_clk), .d(rst_n), .q(wrst_n));
  cdc_sync #(.W(1), .N(SYNC_N)) u_rrst (.clk(rd_clk), .d(rst_n), .q(rrst_n));

  cdc_sync #(.W(PW), .N(SYNC_N)) u_w2r (.clk(rd_clk), .d(wgray), .q(wgray_s));
  cdc_sync #(.W(PW), .N(SYNC_N)) u_r2w (.clk(wr_clk), .d(rgray), .q(rgray_s));

  xfifo_wr #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wr_clk), .rst_n(rst_n), .wrst_n(wrst_n),
    .we_a(wr_en_a), .we_b(wr_en_b), .rgray_s(rgray_s),
    .push(push), .waddr(waddr), .wgray(wgray), .ir(in_rdy), .hf(half_full)
  );

  xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  xfifo_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk(rd_clk), .rst_n(rst_n), .rrst_n(rrst_n),
    .oe(out_en), .re_a(rd_en_a), .re_b(rd_en_b), .wgray_s(wgray_s),
    .rdata(mem_q), .raddr(raddr), .rgray(rgray), .q(rd_data), .valid(out_rdy)
  );
endmodule

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
  localparam int DW = 18;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst_n, wr_en_a, wr_en_b, rd_en_a, rd_en_b, out_en;
  logic [DW-1:0] wr_data;
  logic          in_rdy, half_full, out_rdy;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] exp_q[$];

  always #10 wr_clk = ~wr_clk;
  initial begin
    #7;
    forever #10 rd_clk = ~rd_clk;
  end

  xclk_fifo dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .in_rdy(in_rdy), .half_full(half_full),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .rd_data(rd_data), .out_rdy(out_rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard: accepted words are pushed (R1)
  always @(negedge wr_clk) begin
    if (wr_en_a && wr_en_b && in_rdy) exp_q.push_back(wr_data);
  end

  // monitor: every word taken is compared with the queue head (R10)
  always @(negedge rd_clk) begin
    if (out_rdy && out_en && rd_en_a && rd_en_b) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", int'(rd_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R10 order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic wr_stream(input int n, input int base, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      wr_data = DW'(base + i);
      wr_en_a = 1'b1;
      wr_en_b = 1'b1;
      if (in_rdy) acc++;
      @(posedge wr_clk);
      #2;
    end
    wr_en_a = 1'b0;
    wr_en_b = 1'b0;
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(posedge wr_clk);
    #2;
  endtask

  task automatic w_until(input bit lvl, output int n);
    n = 0;
    do begin
      @(posedge wr_clk);
      #1;
      n++;
    end while (in_rdy != lvl && n < 20);
  endtask

  task automatic r_until(input bit lvl, output int n);
    n = 0;
    do begin
      @(posedge rd_clk);
      #1;
      n++;
    end while (out_rdy != lvl && n < 20);
  endtask

  task automatic rd_set(input logic oe, input logic ea, input logic eb);
    @(posedge rd_clk);
    #2;
    out_en  = oe;
    rd_en_a = ea;
    rd_en_b = eb;
  endtask

  initial begin
    #5_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, nw, nr, acc, tot;
    logic [DW-1:0] held;
    rst_n = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0; wr_data = '0;
    rd_en_a = 1'b0; rd_en_b = 1'b0; out_en = 1'b0;

    wcyc(6);
    chk(in_rdy == 1'b0, "R7 in_rdy in reset", in_rdy, 0);
    chk(out_rdy == 1'b0, "R7 out_rdy in reset", out_rdy, 0);
    chk(half_full == 1'b0, "R7 half_full in reset", half_full, 0);
    #3 rst_n = 1'b1;
    w_until(1'b1, n);
    chk(n == 2, "R8 in_rdy edges after release", n, 2);
    wcyc(4);

    // R3: first word falls through with read enables and out_en low
    wr_data = 18'h2A5C3; wr_en_a = 1'b1; wr_en_b = 1'b1;
    @(posedge wr_clk); #2;
    wr_en_a = 1'b0; wr_en_b = 1'b0;
    r_until(1'b1, n);
    chk(n == 3, "R3 first-word read edges", n, 3);
    chk(rd_data == 18'h2A5C3, "R3 first-word data", int'(rd_data), 'h2A5C3);

    // R2: word held while the read condition is incomplete
    held = rd_data;
    repeat (5) @(posedge rd_clk); #2;
    chk(out_rdy && rd_data == held, "R2 hold idle", int'(rd_data), int'(held));
    out_en = 1'b1; rd_en_a = 1'b1; rd_en_b = 1'b0;
    repeat (4) @(posedge rd_clk); #2;
    chk(out_rdy && rd_data == held, "R2 hold one enable low", int'(rd_data), int'(held));
    out_en = 1'b0; rd_en_b = 1'b1;
    repeat (4) @(posedge rd_clk); #2;
    chk(out_rdy && rd_data == held, "R2 hold out_en low", int'(rd_data), int'(held));

    // R4: taking the only word drops out_rdy on that edge
    out_en = 1'b1;
    @(posedge rd_clk); #1;
    chk(out_rdy == 1'b0, "R4 last read", out_rdy, 0);

    // R3 again with read enables high while empty
    @(posedge wr_clk); #2;
    wr_data = 18'h1B0F0; wr_en_a = 1'b1; wr_en_b = 1'b1;
    @(posedge wr_clk); #2;
    wr_en_a = 1'b0; wr_en_b = 1'b0;
    r_until(1'b1, n);
    chk(n == 3, "R3 latency with enables high", n, 3);
    chk(rd_data == 18'h1B0F0, "R3 data with enables high", int'(rd_data), 'h1B0F0);
    @(posedge rd_clk); #1;
    chk(out_rdy == 1'b0, "R4 last read after fall-through", out_rdy, 0);
    repeat (5) @(posedge rd_clk); #1;
    chk(out_rdy == 1'b0 && exp_q.size() == 0, "R3 no repeated word", out_rdy, 0);
    rd_set(1'b0, 1'b0, 1'b0);

    // R9 / R5 / R1: fill with reads stalled
    @(posedge wr_clk); #2;
    wr_stream(513, 1000, acc); tot = acc;
    chk(acc == 513, "R1 accepted while room", acc, 513);
    wcyc(10);
    chk(half_full == 1'b0, "R9 low at 512 in memory", half_full, 0);
    wr_stream(1, 2000, acc); tot += acc;
    wcyc(10);
    chk(half_full == 1'b1, "R9 high at 513 in memory", half_full, 1);
    wr_stream(600, 3000, acc); tot += acc;
    chk(tot == 1025, "R5 total capacity", tot, 1025);
    chk(in_rdy == 1'b0, "R5 in_rdy low when full", in_rdy, 0);

    // R6: one read relieves the full condition
    rd_set(1'b1, 1'b1, 1'b1);
    @(posedge rd_clk); #2;
    out_en = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0;
    w_until(1'b1, n);
    chk(n == 2, "R6 in_rdy edges after read", n, 2);
    #1;
    wr_stream(3, 5000, acc);
    chk(acc == 1, "R1 only one refill word taken", acc, 1);
    chk(in_rdy == 1'b0, "R5 full again", in_rdy, 0);

    // drain everything, discarded words must not show up (R1, R10)
    rd_set(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 1400 && (exp_q.size() != 0 || out_rdy); i++) begin
      @(posedge rd_clk); #1;
    end
    repeat (5) @(posedge rd_clk); #1;
    chk(exp_q.size() == 0 && !out_rdy, "R10 drained in order", exp_q.size(), 0);
    wcyc(10);
    chk(half_full == 1'b0, "R9 low after drain", half_full, 0);
    chk(in_rdy == 1'b1, "R6 room after drain", in_rdy, 1);

    // R7: reset while holding data
    rd_set(1'b0, 1'b0, 1'b0);
    @(posedge wr_clk); #2;
    wr_stream(3, 7000, acc);
    wcyc(8);
    chk(out_rdy == 1'b1, "R3 ready before reset", out_rdy, 1);
    #3 rst_n = 1'b0;
    fork
      w_until(1'b0, nw);
      r_until(1'b0, nr);
    join
    chk(nw == 2, "R7 in_rdy fall edges", nw, 2);
    chk(nr == 3, "R7 out_rdy fall edges", nr, 3);
    exp_q.delete();
    wcyc(3);
    chk(half_full == 1'b0, "R7 half_full in reset", half_full, 0);
    #3 rst_n = 1'b1;
    w_until(1'b1, n);
    chk(n == 2, "R8 in_rdy after second release", n, 2);
    chk(out_rdy == 1'b0, "R7 empty after reset", out_rdy, 0);

    // traffic after reset
    @(posedge wr_clk); #2;
    wr_stream(5, 9000, acc);
    chk(acc == 5, "R1 writes after reset", acc, 5);
    rd_set(1'b1, 1'b1, 1'b1);
    repeat (20) @(posedge rd_clk); #1;
    chk(exp_q.size() == 0 && !out_rdy, "R10 post-reset drain", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule